// File: doc/BRIEF.md
# Display Serial Command/Data Transmitter

This block is a write-only serializer for a display controller that listens on a chip-select, serial-clock and serial-data link. A byte and a command/data flag arrive through a valid/ready handshake. The flag reads as data when high and as command when low. Each accepted byte is shifted out most significant bit first. The link uses clock polarity 0 and phase 0: the serial clock idles low, data moves on falling edges and is stable on rising edges. The serial clock runs at the system clock divided by `2*HALF_PERIOD`.

A run-time mode input picks one of three framings, and the block samples it only while idle. In the 9-bit framing the flag bit is sent in-band ahead of the byte. In the 16-bit framing the flag sits in-band behind seven zero padding bits. In the 8-bit framing only the byte is shifted and the flag appears on a dedicated flag line. If a new byte is valid when a word ends, chip select stays low and the next word follows at once. The block also registers an active-low reset output for the panel.

Top module: `dbi_serial_tx`

## Requirements
- R1: With mode 2'b01, each byte is sent as 9 serial clocks: the flag bit, then D7 down to D0.
- R2: With mode 2'b10, each byte is sent as 16 serial clocks: seven 0 bits, then the flag bit, then D7 down to D0.
- R3: With mode 2'b00 or 2'b11, each byte is sent as 8 serial clocks, D7 down to D0. The flag line `dcx_o` equals the flag (1 = data, 0 = command) at every rising serial-clock edge of that byte.
- R4: With mode 2'b01 or 2'b10, `dcx_o` stays 0 during the word.
- R5: The serial clock is low whenever chip select is high. `sdo_o` changes only in cycles where the serial clock is low.
- R6: Chip select falls `HALF_PERIOD` system cycles before the first rising edge. Rising edges within a frame are `2*HALF_PERIOD` cycles apart. Chip select rises `HALF_PERIOD` cycles after the last falling edge.
- R7: If a new byte is valid when a word ends, it is taken at once and chip select stays low across both words.
- R8: If no byte is valid at the end of a word, chip select is released after the last bit.
- R9: The mode input is sampled only when the block is idle. A change during a word does not alter that word.
- R10: `in_ready` is high only while idle or in the cycle that completes a word's last clock. It is low while the bits of a word are shifting.
- R11: `resx_n_o` is low during system reset. After reset it equals the inverse of `panel_rst_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mode_i | input | 2 | Framing: 00/11 8-bit with flag line, 01 9-bit, 10 16-bit |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte taken on this edge when valid |
| in_data | input | 8 | Byte to send |
| in_is_data | input | 1 | Flag: 1 data, 0 command |
| panel_rst_i | input | 1 | Request to hold the panel in reset |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| dcx_o | output | 1 | Separate flag line (8-bit framing) |
| resx_n_o | output | 1 | Panel reset, active low |

## Verification
Chip select falls one system cycle after the accepting edge. The first rising serial edge follows `HALF_PERIOD` cycles later. Each bit then takes `2*HALF_PERIOD` cycles, chip select rises `HALF_PERIOD` cycles after the final falling edge, and the reset output follows its request after one cycle. The bench decodes bits at each rising serial edge and timestamps the chip-select and clock edges at falling system-clock edges. It compares a word only after chip select has risen and two more falling system edges have passed, so every register on the path has settled.

// File: rtl/dbi_tx_pkg.sv
package dbi_tx_pkg;

    localparam int WORD_W = 16;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        FMT_8_LINE = 2'b00,
        FMT_9_BIT  = 2'b01,
        FMT_16_BIT = 2'b10,
        FMT_8_ALT  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [WORD_W-1:0] sh;
        logic [LEN_W-1:0]  left;
        fmt_e              mode;
        logic              cs_n;
        logic              sclk;
        logic              dcx;
        logic              resx_n;
    } core_s;

endpackage

// File: rtl/dbi_word_fmt.sv
module dbi_word_fmt
    import dbi_tx_pkg::*;
(
    input  fmt_e              mode,
    input  logic              flag,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word,
    output logic [LEN_W-1:0]  len,
    output logic              four_line
);

    // Words are left-aligned so the shifter always emits bit WORD_W-1.
    always_comb begin
        word      = '0;
        len       = LEN_W'(8);
        four_line = 1'b0;
        unique case (mode)
            FMT_9_BIT: begin
                word[WORD_W-1 -: 9] = {flag, byte_in};
                len                 = LEN_W'(9);
            end
            FMT_16_BIT: begin
                word = {7'b0, flag, byte_in};
                len  = LEN_W'(16);
            end
            default: begin
                word[WORD_W-1 -: 8] = byte_in;
                len                 = LEN_W'(8);
                four_line           = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dbi_half_tick.sv
module dbi_half_tick #(
    parameter int HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_PERIOD <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_PERIOD);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = run && (cnt_q == CW'(HALF_PERIOD - 1));
                cnt_d = cnt_q;
                if (!run)      cnt_d = '0;
                else if (tick) cnt_d = '0;
                else           cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate

endmodule

// File: rtl/dbi_tx_core.sv
module dbi_tx_core
    import dbi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  fmt_e              mode_i,
    input  logic              in_valid,
    input  logic              flag,
    input  logic [WORD_W-1:0] word,
    input  logic [LEN_W-1:0]  len,
    input  logic              four_line,
    input  logic              panel_rst_i,
    output fmt_e              mode_eff,
    output logic              in_ready,
    output logic              run,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo,
    output logic              dcx,
    output logic              resx_n
);

    core_s q, d;

    localparam core_s RST = '{
        st:     ST_IDLE,
        sh:     '0,
        left:   '0,
        mode:   FMT_8_LINE,
        cs_n:   1'b1,
        sclk:   1'b0,
        dcx:    1'b0,
        resx_n: 1'b0
    };

    always_comb begin
        d        = q;
        in_ready = 1'b0;
        run      = (q.st != ST_IDLE);
        mode_eff = (q.st == ST_IDLE) ? mode_i : q.mode;
        d.resx_n = ~panel_rst_i;

        unique case (q.st)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_LOW: begin
                if (tick) begin
                    d.sclk = 1'b1;
                    d.st   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    d.sclk = 1'b0;
                    if (q.left == LEN_W'(1)) begin
                        in_ready = 1'b1;
                        d.st     = ST_HOLD;
                    end else begin
                        d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                        d.left = q.left - 1'b1;
                        d.st   = ST_LOW;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    d.cs_n = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d = RST;
        endcase

        // A byte taken here starts a word, either from idle or back-to-back.
        if (in_ready && in_valid) begin
            d.sh   = word;
            d.left = len;
            d.mode = mode_eff;
            d.cs_n = 1'b0;
            d.dcx  = four_line ? flag : 1'b0;
            d.st   = ST_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign cs_n   = q.cs_n;
    assign sclk   = q.sclk;
    assign sdo    = q.sh[WORD_W-1];
    assign dcx    = q.dcx;
    assign resx_n = q.resx_n;

endmodule

// File: rtl/dbi_serial_tx.sv
module dbi_serial_tx
    import dbi_tx_pkg::*;
#(
    parameter int HALF_PERIOD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_is_data,
    input  logic       panel_rst_i,
    output logic       cs_n_o,
    output logic       sclk_o,
    output logic       sdo_o,
    output logic       dcx_o,
    output logic       resx_n_o
);

    fmt_e              mode_eff;
    logic [WORD_W-1:0] word;
    logic [LEN_W-1:0]  len;
    logic              four_line;
    logic              run;
    logic              tick;

    dbi_word_fmt i_fmt (
        .mode      (mode_eff),
        .flag      (in_is_data),
        .byte_in   (in_data),
        .word      (word),
        .len       (len),
        .four_line (four_line)
    );

    dbi_half_tick #(.HALF_PERIOD(HALF_PERIOD)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    dbi_tx_core i_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .mode_i      (fmt_e'(mode_i)),
        .in_valid    (in_valid),
        .flag        (in_is_data),
        .word        (word),
        .len         (len),
        .four_line   (four_line),
        .panel_rst_i (panel_rst_i),
        .mode_eff    (mode_eff),
        .in_ready    (in_ready),
        .run         (run),
        .cs_n        (cs_n_o),
        .sclk        (sclk_o),
        .sdo         (sdo_o),
        .dcx         (dcx_o),
        .resx_n      (resx_n_o)
    );

endmodule

// File: rtl/dbi_serial_tx_chk.sv
module dbi_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic panel_rst_i,
    input logic cs_n_o,
    input logic sclk_o,
    input logic sdo_o,
    input logic resx_n_o
);

    a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    a_r5_sdo_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> !sclk_o);

    a_r6_rise_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> (!cs_n_o && $past(!cs_n_o)));

    a_r8_release_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> $past(!sclk_o));

    a_r10_accept_at_word_end: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !cs_n_o) |-> sclk_o);

    a_r11_reset_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> (resx_n_o == !$past(panel_rst_i)));

endmodule

bind dbi_serial_tx dbi_serial_tx_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .panel_rst_i (panel_rst_i),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .sdo_o       (sdo_o),
    .resx_n_o    (resx_n_o)
);

// File: tb/test_dbi_serial_tx.sv
`timescale 1ns/1ps
module test_dbi_serial_tx;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_is_data = 1'b0;
    logic       panel_rst_i = 1'b1;
    logic       cs_n_o, sclk_o, sdo_o, dcx_o, resx_n_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbi_serial_tx #(.HALF_PERIOD(HALF)) i_dbi_serial_tx (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_is_data(in_is_data),
        .panel_rst_i(panel_rst_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .sdo_o(sdo_o), .dcx_o(dcx_o), .resx_n_o(resx_n_o)
    );

    // Serial capture: bits and flag line at each rising serial edge.
    logic [31:0] cap_val, cap_dcx;
    int          cap_n;
    always @(posedge sclk_o or negedge cs_n_o) begin
        if (sclk_o) begin
            cap_val = {cap_val[30:0], sdo_o};
            cap_dcx = {cap_dcx[30:0], dcx_o};
            cap_n   = cap_n + 1;
        end else begin
            cap_val = '0;
            cap_dcx = '0;
            cap_n   = 0;
        end
    end

    // Edge timestamps in system cycles.
    int cyc = 0, t_csf = 0, t_r1 = 0, t_lr = 0, t_lf = 0, t_csr = 0, nfr = 0;
    bit first = 0, per_bad = 0;
    logic p_cs = 1'b1, p_sclk = 1'b0;
    always @(negedge clk) begin
        if (p_cs && !cs_n_o) begin t_csf = cyc; first = 1; per_bad = 0; nfr = nfr + 1; end
        if (!p_sclk && sclk_o) begin
            if (first) t_r1 = cyc;
            else if (cyc - t_lr != 2*HALF) per_bad = 1;
            t_lr = cyc; first = 0;
        end
        if (p_sclk && !sclk_o) t_lf = cyc;
        if (!p_cs && cs_n_o) t_csr = cyc;
        p_cs = cs_n_o; p_sclk = sclk_o;
        cyc = cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic f, input logic [7:0] b);
        @(negedge clk);
        mode_i = m; in_data = b; in_is_data = f; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_frame();
        @(posedge cs_n_o);
        repeat (2) @(negedge clk);
    endtask

    // {mode, flag, byte, length, dcx ones, expected right-aligned bits}
    localparam int NV = 8;
    localparam logic [36:0] VEC [NV] = '{
        {2'b01, 1'b0, 8'h2A, 5'd9,  5'd0, 16'h002A},
        {2'b01, 1'b1, 8'hC3, 5'd9,  5'd0, 16'h01C3},
        {2'b10, 1'b0, 8'h5A, 5'd16, 5'd0, 16'h005A},
        {2'b10, 1'b1, 8'hFF, 5'd16, 5'd0, 16'h01FF},
        {2'b00, 1'b0, 8'hA5, 5'd8,  5'd0, 16'h00A5},
        {2'b00, 1'b1, 8'h3C, 5'd8,  5'd8, 16'h003C},
        {2'b11, 1'b1, 8'h81, 5'd8,  5'd8, 16'h0081},
        {2'b01, 1'b1, 8'h00, 5'd9,  5'd0, 16'h0100}
    };

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1, "R5 reset cs_n", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R5 reset sclk", sclk_o, 0);
        chk(resx_n_o == 1'b0, "R11 reset resx_n low", resx_n_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        panel_rst_i = 1'b0;
        @(negedge clk);
        chk(resx_n_o == 1'b1, "R11 resx_n released", resx_n_o, 1);

        for (int i = 0; i < NV; i++) begin
            int fr0;
            fr0 = nfr;
            send(VEC[i][36:35], VEC[i][34], VEC[i][33:26]);
            wait_frame();
            chk(cap_n == int'(VEC[i][25:21]), "R1 R2 R3 word length", cap_n, VEC[i][25:21]);
            chk(cap_val == {16'h0, VEC[i][15:0]}, "R1 R2 R3 word bits", cap_val, VEC[i][15:0]);
            chk($countones(cap_dcx) == int'(VEC[i][20:16]), "R3 R4 flag line", cap_dcx, VEC[i][20:16]);
            chk(nfr - fr0 == 1, "R8 one frame per lone byte", nfr - fr0, 1);
            chk(t_r1 - t_csf == HALF, "R6 lead", t_r1 - t_csf, HALF);
            chk(t_csr - t_lf == HALF, "R6 tail", t_csr - t_lf, HALF);
            chk(!per_bad, "R6 period", per_bad, 0);
        end

        // R10: no acceptance while bits shift.
        begin
            send(2'b10, 1'b0, 8'h77);
            repeat (3) @(negedge clk);
            chk(in_ready == 1'b0, "R10 ready low mid-word", in_ready, 0);
            wait_frame();
        end

        // R7: back-to-back 9-bit words under one chip select.
        begin
            int fr0;
            fr0 = nfr;
            send(2'b01, 1'b0, 8'h2C);
            send(2'b01, 1'b1, 8'h12);
            wait_frame();
            chk(nfr - fr0 == 1, "R7 cs held low", nfr - fr0, 1);
            chk(cap_n == 18, "R7 bit count", cap_n, 18);
            chk(cap_val == 32'({9'h02C, 9'h112}), "R7 bits", cap_val, 32'({9'h02C, 9'h112}));
        end

        // R7 R3: back-to-back 8-bit with flag change between bytes.
        begin
            send(2'b00, 1'b0, 8'h11);
            send(2'b00, 1'b1, 8'h22);
            wait_frame();
            chk(cap_val == 32'h1122, "R7 8-bit bits", cap_val, 32'h1122);
            chk(cap_dcx == 32'h00FF, "R3 flag per byte", cap_dcx, 32'h00FF);
        end

        // R9: mode change during a word is ignored.
        begin
            send(2'b01, 1'b1, 8'h5C);
            mode_i = 2'b10;
            wait_frame();
            chk(cap_n == 9, "R9 length kept", cap_n, 9);
            chk(cap_val == 32'h15C, "R9 bits kept", cap_val, 32'h15C);
        end

        // R11: reset request reasserted.
        @(negedge clk);
        panel_rst_i = 1'b1;
        @(negedge clk);
        chk(resx_n_o == 1'b0, "R11 resx_n reasserted", resx_n_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule